// File: doc/BRIEF.md
# SECDED Protected Word Memory Wrapper

This block sits between a requester and a single-port RAM that is 39 bits wide. On a write it takes a 32-bit data word and builds a 39-bit codeword: a Hamming code with six check bits, an overall parity bit, and two check bits stored inverted. The RAM itself lives outside the wrapper. The wrapper drives its enable, write strobe, address and codeword, and it takes the registered read word back one cycle later.

On a read the wrapper decodes the returned codeword and corrects any single flipped bit. It flags a two-bit error as uncorrectable. It also flags a word that reads back as all zeros or all ones, so a stuck row or a dead RAM never passes as good data. The memory only takes whole-word writes, but a read may ask for a byte, a half-word or the full word. The lane is always cut from the corrected word.

A two-state controller sequences the accesses. In `ST_IDLE` a request is accepted. A write finishes in that cycle, taking transition `IDLE_WRITE`, and stays in `ST_IDLE`. A read takes transition `IDLE_READ` to `ST_FETCH`, where the RAM word is on `mem_rdata`. The transition `FETCH_DONE` returns to `ST_IDLE` and registers the response.

Top module: `ecc_ram_wrap`

## Requirements
- R1: While reset is held and on the first cycle after it, `req_ready` is 1, and `rsp_valid`, `mem_en` and `mem_we` are 0.
- R2: A write is accepted in a cycle with `req_valid`, `req_ready` and `req_write` all high. In that same cycle the wrapper drives `mem_en`=1 and `mem_we`=1 with `req_addr`. A write produces no response, and `req_ready` stays 1 on the next cycle.
- R3: A read is accepted in a cycle with `req_valid` and `req_ready` high and `req_write` low. In that cycle the wrapper drives `mem_en`=1 and `mem_we`=0. On the next cycle `req_ready` is 0. On the cycle after that, `rsp_valid` is 1 for exactly one cycle, with a result decoded from the `mem_rdata` present in the cycle between.
- R4: Reading a word that came back unaltered returns the written data, with `rsp_corrected`=0 and `rsp_uncorrectable`=0.
- R5: A single flipped bit at any of the 39 codeword positions gives back the original data, with `rsp_corrected`=1 and `rsp_uncorrectable`=0.
- R6: Two flipped bits give `rsp_uncorrectable`=1 and `rsp_corrected`=0.
- R7: A read word whose 39 bits are all 0 or all 1 gives `rsp_uncorrectable`=1 and `rsp_corrected`=0.
- R8: No written codeword is all zeros or all ones. This holds for data 0x00000000 and 0xFFFFFFFF as well.
- R9: `req_size`=2'b00 selects a byte read. `req_offset` n selects data bits [8n+7:8n], and the byte is zero-extended in `rsp_rdata`.
- R10: `req_size`=2'b01 selects a half-word read. `req_offset[1]`=0 selects bits [15:0] and 1 selects bits [31:16]. `req_offset[0]` is ignored, and the upper 16 bits of `rsp_rdata` are 0.
- R11: `req_size`=2'b10 or 2'b11 returns the full word, and `req_offset` is ignored.
- R12: A sub-word read is cut from the corrected word. A flipped data bit inside the selected lane still returns the original lane, with `rsp_corrected`=1.
- R13: A request presented while `req_ready` is 0 is ignored. No RAM access is made (`mem_en`=0), and no extra response follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Wrapper can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 32 | Write data |
| req_size | input | 2 | Read width: 00 byte, 01 half, 10/11 word |
| req_offset | input | 2 | Byte offset inside the word for sub-word reads |
| rsp_valid | output | 1 | Read result valid (one-cycle pulse) |
| rsp_rdata | output | 32 | Corrected, lane-aligned, zero-extended read data |
| rsp_corrected | output | 1 | A single-bit error was corrected |
| rsp_uncorrectable | output | 1 | Double error or stuck word detected |
| mem_en | output | 1 | RAM access enable |
| mem_we | output | 1 | RAM write strobe |
| mem_addr | output | ADDR_W | RAM word address |
| mem_wdata | output | 39 | Codeword to store |
| mem_rdata | input | 39 | Codeword read, valid one cycle after the access |

## Verification
The bench builds the wrapper with `ADDR_W`=4 and models a 16-entry RAM, so it can write to any location directly and corrupt a stored codeword between the write and the read. The data width stays at 32, which gives the full 39-bit codeword. That lets the bench flip every single position, including the parity bit and both inverted check bits, as well as several bit pairs and both stuck patterns. Sub-word reads are swept over every byte offset and both half-word halves, and the same corrupted words are read back through sub-word lanes.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

    localparam int DATA_W = 32;

    // smallest number of Hamming check bits covering DATA_W data bits
    function automatic int hamming_bits(input int dw);
        int p;
        p = 0;
        while ((1 << p) < (dw + p + 1)) p++;
        return p;
    endfunction

    localparam int HAM_W  = hamming_bits(DATA_W);
    localparam int CODE_W = DATA_W + HAM_W + 1;

    function automatic logic is_pow2(input int x);
        return (x != 0) && ((x & (x - 1)) == 0);
    endfunction

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_FETCH = 1'b1
    } ctl_state_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_HALF = 2'b01,
        SZ_WORD = 2'b10,
        SZ_WALT = 2'b11
    } rd_size_e;

endpackage

// File: rtl/ecc_encode.sv
module ecc_encode
    import ecc_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int PW = HAM_W,
    parameter int CW = CODE_W
) (
    input  logic [DW-1:0] data,
    output logic [CW-1:0] code
);

    always_comb begin
        logic [CW-1:0] c;
        int            d;
        logic          par;
        c = '0;
        d = 0;
        // spread data over the non power-of-two positions
        for (int pos = 1; pos < CW; pos++) begin
            if (!is_pow2(pos)) begin
                c[pos] = data[d];
                d++;
            end
        end
        // Hamming check bits at power-of-two positions
        for (int k = 0; k < PW; k++) begin
            par = 1'b0;
            for (int pos = 1; pos < CW; pos++) begin
                if (pos[k]) par = par ^ c[pos];
            end
            c[1 << k] = par;
        end
        // overall parity at position 0
        c[0] = ^c[CW-1:1];
        // invert two check bits so no valid word is all zeros or all ones
        c[1] = ~c[1];
        c[2] = ~c[2];
        code = c;
    end

endmodule

// File: rtl/ecc_decode.sv
module ecc_decode
    import ecc_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int PW = HAM_W,
    parameter int CW = CODE_W
) (
    input  logic [CW-1:0] code,
    output logic [DW-1:0] data,
    output logic          corrected,
    output logic          uncorrectable
);

    logic [CW-1:0] plain;
    logic [PW-1:0] syn;
    logic          par_odd;
    logic          stuck;
    logic          syn_in_range;
    logic [CW-1:0] fixed;

    always_comb begin
        plain    = code;
        plain[1] = ~code[1];
        plain[2] = ~code[2];
    end

    always_comb begin
        syn = '0;
        for (int k = 0; k < PW; k++) begin
            for (int pos = 1; pos < CW; pos++) begin
                if (pos[k]) syn[k] = syn[k] ^ plain[pos];
            end
        end
    end

    assign par_odd      = ^plain;
    assign stuck        = (code == '0) || (&code);
    assign syn_in_range = (int'(syn) < CW);

    always_comb begin
        fixed = plain;
        if (!stuck && par_odd && (syn != '0) && syn_in_range)
            fixed[int'(syn)] = ~plain[int'(syn)];
    end

    always_comb begin
        int d;
        d    = 0;
        data = '0;
        for (int pos = 1; pos < CW; pos++) begin
            if (!is_pow2(pos)) begin
                data[d] = fixed[pos];
                d++;
            end
        end
    end

    always_comb begin
        corrected     = 1'b0;
        uncorrectable = 1'b0;
        if (stuck) begin
            uncorrectable = 1'b1;
        end else if (par_odd) begin
            if (syn_in_range) corrected     = 1'b1;
            else              uncorrectable = 1'b1;
        end else if (syn != '0) begin
            uncorrectable = 1'b1;
        end
    end

    always_comb begin
        if (code == '0 || (&code))
            assert_stuck_flag_R7: assert (uncorrectable && !corrected);
    end

endmodule

// File: rtl/ecc_lane_sel.sv
module ecc_lane_sel
    import ecc_pkg::*;
#(
    parameter int DW = DATA_W
) (
    input  logic [DW-1:0] word,
    input  logic [1:0]    size,
    input  logic [1:0]    offset,
    output logic [DW-1:0] lane
);

    localparam int LANES = DW / 8;

    logic [7:0]  bytes [LANES];
    logic [15:0] halves[LANES/2];

    for (genvar g = 0; g < LANES; g++) begin : g_byte
        assign bytes[g] = word[8*g +: 8];
    end
    for (genvar h = 0; h < LANES/2; h++) begin : g_half
        assign halves[h] = word[16*h +: 16];
    end

    always_comb begin
        lane = '0;
        unique case (rd_size_e'(size))
            SZ_BYTE: lane[7:0]  = bytes[offset];
            SZ_HALF: lane[15:0] = halves[offset[1]];
            SZ_WORD,
            SZ_WALT: lane       = word;
        endcase
    end

endmodule

// File: rtl/ecc_ram_wrap.sv
module ecc_ram_wrap
    import ecc_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    input  logic [1:0]        req_size,
    input  logic [1:0]        req_offset,
    output logic              rsp_valid,
    output logic [31:0]       rsp_rdata,
    output logic              rsp_corrected,
    output logic              rsp_uncorrectable,
    output logic              mem_en,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [38:0]       mem_wdata,
    input  logic [38:0]       mem_rdata
);

    ctl_state_e          state_q, state_d;
    logic [1:0]          size_q;
    logic [1:0]          offset_q;
    logic [CODE_W-1:0]   enc_code;
    logic [DATA_W-1:0]   dec_data;
    logic                dec_corr;
    logic                dec_unc;
    logic [DATA_W-1:0]   lane_data;
    logic                rd_accept;

    ecc_encode u_enc (
        .data (req_wdata),
        .code (enc_code)
    );

    ecc_decode u_dec (
        .code          (mem_rdata),
        .data          (dec_data),
        .corrected     (dec_corr),
        .uncorrectable (dec_unc)
    );

    ecc_lane_sel u_lane (
        .word   (dec_data),
        .size   (size_q),
        .offset (offset_q),
        .lane   (lane_data)
    );

    // next state and RAM-side controls
    always_comb begin
        state_d   = state_q;
        req_ready = (state_q == ST_IDLE);
        mem_en    = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = req_addr;
        mem_wdata = enc_code;
        rd_accept = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    mem_en = 1'b1;
                    mem_we = req_write;
                    if (!req_write) begin   // IDLE_READ
                        rd_accept = 1'b1;
                        state_d   = ST_FETCH;
                    end                     // IDLE_WRITE otherwise
                end
            end
            ST_FETCH: state_d = ST_IDLE;    // FETCH_DONE
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // registered outputs and captured read shape
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            size_q            <= '0;
            offset_q          <= '0;
            rsp_valid         <= 1'b0;
            rsp_rdata         <= '0;
            rsp_corrected     <= 1'b0;
            rsp_uncorrectable <= 1'b0;
        end else begin
            if (rd_accept) begin
                size_q   <= req_size;
                offset_q <= req_offset;
            end
            rsp_valid <= (state_q == ST_FETCH);
            if (state_q == ST_FETCH) begin
                rsp_rdata         <= lane_data;
                rsp_corrected     <= dec_corr;
                rsp_uncorrectable <= dec_unc;
            end
        end
    end

    assert_read_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write) |-> ##2 rsp_valid);

    assert_read_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write) |=> !req_ready);

    assert_rsp_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    assert_write_no_rsp_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_write) |=> (!rsp_valid && req_ready));

    assert_busy_no_mem_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !req_ready |-> !mem_en);

    assert_flags_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !(rsp_corrected && rsp_uncorrectable));

    assert_no_stuck_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && mem_we) |-> (mem_wdata != '0 && mem_wdata != '1));

endmodule

// File: tb/ecc_ram_wrap_tb.sv
module ecc_ram_wrap_tb;

    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic [1:0]    req_size = 2'b10;
    logic [1:0]    req_offset = 2'b00;
    logic          rsp_valid;
    logic [31:0]   rsp_rdata;
    logic          rsp_corrected;
    logic          rsp_uncorrectable;
    logic          mem_en;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [38:0]   mem_wdata;
    logic [38:0]   mem_rdata;

    logic [38:0]   ram [16];
    int            n_checks = 0;
    int            n_errors = 0;
    logic          done = 1'b0;

    always #10 clk = ~clk;

    ecc_ram_wrap #(.ADDR_W(AW)) u_dut (
        .clk               (clk),
        .rst_n             (rst_n),
        .req_valid         (req_valid),
        .req_ready         (req_ready),
        .req_write         (req_write),
        .req_addr          (req_addr),
        .req_wdata         (req_wdata),
        .req_size          (req_size),
        .req_offset        (req_offset),
        .rsp_valid         (rsp_valid),
        .rsp_rdata         (rsp_rdata),
        .rsp_corrected     (rsp_corrected),
        .rsp_uncorrectable (rsp_uncorrectable),
        .mem_en            (mem_en),
        .mem_we            (mem_we),
        .mem_addr          (mem_addr),
        .mem_wdata         (mem_wdata),
        .mem_rdata         (mem_rdata)
    );

    // RAM model: registered read
    always @(posedge clk) begin
        if (mem_en) begin
            if (mem_we) ram[mem_addr] <= mem_wdata;
            else        mem_rdata     <= ram[mem_addr];
        end
    end

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        #1;
        check("R2 mem_en/we on write", {62'd0, mem_en, mem_we}, 64'd3);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        check("R2 ready after write", {63'd0, req_ready}, 64'd1);
        check("R2 no response to write", {63'd0, rsp_valid}, 64'd0);
    endtask

    task automatic do_read(input logic [AW-1:0] a, input logic [1:0] sz, input logic [1:0] off,
                           output logic [31:0] d, output logic corr, output logic unc);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a; req_size = sz; req_offset = off;
        #1;
        check("R3 mem_en on read", {62'd0, mem_en, mem_we}, 64'd2);
        @(negedge clk);
        req_valid = 1'b0;
        check("R3 busy cycle", {62'd0, req_ready, rsp_valid}, 64'd0);
        @(negedge clk);
        check("R3 rsp_valid", {63'd0, rsp_valid}, 64'd1);
        d = rsp_rdata; corr = rsp_corrected; unc = rsp_uncorrectable;
        @(negedge clk);
        check("R3 single pulse", {63'd0, rsp_valid}, 64'd0);
    endtask

    task automatic t_reset;
        #1;
        check("R1 reset outputs", {60'd0, req_ready, rsp_valid, mem_en, mem_we}, 64'h8);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", {60'd0, req_ready, rsp_valid, mem_en, mem_we}, 64'h8);
    endtask

    task automatic t_clean;
        logic [31:0] d; logic c, u;
        do_write(4'd1, 32'hDEADBEEF);
        do_read(4'd1, 2'b10, 2'b00, d, c, u);
        check("R4 clean data", {32'd0, d}, {32'd0, 32'hDEADBEEF});
        check("R4 clean flags", {62'd0, c, u}, 64'd0);
        do_write(4'd2, 32'h0000_0000);
        check("R8 zero data codeword", {63'd0, (ram[2] == '0) || (ram[2] == '1)}, 64'd0);
        do_read(4'd2, 2'b10, 2'b00, d, c, u);
        check("R4 zero data round trip", {30'd0, c, u, d}, 64'd0);
        do_write(4'd3, 32'hFFFF_FFFF);
        check("R8 ones data codeword", {63'd0, (ram[3] == '0) || (ram[3] == '1)}, 64'd0);
        do_read(4'd3, 2'b11, 2'b01, d, c, u);
        check("R11 full word size 11", {30'd0, c, u, d}, {32'd0, 32'hFFFF_FFFF});
    endtask

    task automatic t_single;
        logic [31:0] d; logic c, u;
        for (int p = 0; p < 39; p++) begin
            do_write(4'd5, 32'hA5C3_1E77 ^ (32'h1 << (p % 32)));
            @(negedge clk);
            ram[5][p] = ~ram[5][p];
            do_read(4'd5, 2'b10, 2'b00, d, c, u);
            check("R5 single corrected data", {32'd0, d}, {32'd0, 32'hA5C3_1E77 ^ (32'h1 << (p % 32))});
            check("R5 single flags", {62'd0, c, u}, 64'd2);
        end
    endtask

    task automatic t_double;
        logic [31:0] d; logic c, u;
        int pa[5] = '{0, 1, 3, 10, 37};
        int pb[5] = '{5, 2, 38, 20, 38};
        for (int i = 0; i < 5; i++) begin
            do_write(4'd6, 32'h1234_5678);
            @(negedge clk);
            ram[6][pa[i]] = ~ram[6][pa[i]];
            ram[6][pb[i]] = ~ram[6][pb[i]];
            do_read(4'd6, 2'b10, 2'b00, d, c, u);
            check("R6 double flags", {62'd0, c, u}, 64'd1);
        end
    endtask

    task automatic t_stuck;
        logic [31:0] d; logic c, u;
        @(negedge clk); ram[7] = '0;
        do_read(4'd7, 2'b10, 2'b00, d, c, u);
        check("R7 all zeros word", {62'd0, c, u}, 64'd1);
        @(negedge clk); ram[7] = '1;
        do_read(4'd7, 2'b10, 2'b00, d, c, u);
        check("R7 all ones word", {62'd0, c, u}, 64'd1);
    endtask

    task automatic t_subword;
        logic [31:0] d; logic c, u;
        do_write(4'd8, 32'h8899_AABB);
        for (int o = 0; o < 4; o++) begin
            do_read(4'd8, 2'b00, 2'(o), d, c, u);
            check("R9 byte lane", {32'd0, d}, {32'd0, 24'd0, 8'(32'h8899_AABB >> (8*o))});
        end
        for (int o = 0; o < 4; o++) begin
            do_read(4'd8, 2'b01, 2'(o), d, c, u);
            check("R10 half lane", {32'd0, d}, {32'd0, 16'd0, 16'(32'h8899_AABB >> (16*(o/2)))});
        end
        do_read(4'd8, 2'b10, 2'b11, d, c, u);
        check("R11 word ignores offset", {32'd0, d}, {32'd0, 32'h8899_AABB});
    endtask

    task automatic t_lane_fix;
        logic [31:0] d; logic c, u;
        do_write(4'd9, 32'h0F1E_2D3C);
        @(negedge clk);
        ram[9][38] = ~ram[9][38];   // highest data bit, in byte 3
        do_read(4'd9, 2'b00, 2'b11, d, c, u);
        check("R12 byte from corrected word", {31'd0, c, d}, {31'd0, 1'b1, 32'h0000_000F});
        do_read(4'd9, 2'b01, 2'b10, d, c, u);
        check("R12 half from corrected word", {31'd0, c, d}, {31'd0, 1'b1, 32'h0000_0F1E});
    endtask

    task automatic t_busy;
        logic [31:0] d; logic c, u;
        do_write(4'd10, 32'h1111_2222);
        do_write(4'd11, 32'h3333_4444);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = 4'd10; req_size = 2'b10; req_offset = 2'b00;
        @(negedge clk);
        req_write = 1'b1; req_addr = 4'd11; req_wdata = 32'h5555_6666;
        #1;
        check("R13 no RAM access while busy", {63'd0, mem_en}, 64'd0);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
        check("R13 first read response", {31'd0, rsp_valid, rsp_rdata}, {31'd0, 1'b1, 32'h1111_2222});
        @(negedge clk);
        check("R13 no extra response", {63'd0, rsp_valid}, 64'd0);
        do_read(4'd11, 2'b10, 2'b00, d, c, u);
        check("R13 ignored write left word", {32'd0, d}, {32'd0, 32'h3333_4444});
    endtask

    initial begin
        t_reset();
        t_clean();
        t_single();
        t_double();
        t_stuck();
        t_subword();
        t_lane_fix();
        t_busy();
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

endmodule